// File: doc/BRIEF.md
# APB Requester Transfer Controller

This block sits between a local requester and a single APB completer. The requester offers commands over a valid/ready handshake. Each command carries an address, a direction flag, write data, byte-lane strobes and protection bits. The block turns each accepted command into a two-phase APB transfer and returns the read data and the completer's error flag through a one-cycle response pulse.

The controller is a three-state machine:

- **ST_IDLE**: no transfer on the bus.
- **ST_SETUP**: select high, enable low. It always lasts exactly one cycle.
- **ST_ACCESS**: select and enable both high. It lasts until the completer raises ready.

The named transitions are:

- **go** (IDLE→SETUP): a command is accepted while idle.
- **arm** (SETUP→ACCESS): unconditional.
- **stall** (ACCESS→ACCESS): the completer is not ready.
- **chain** (ACCESS→SETUP): the transfer completes while another command is pending. Select stays high.
- **retire** (ACCESS→IDLE): the transfer completes and no command is pending.
- **park** (IDLE→IDLE): no command is offered.

When commands are queued, transfers run back to back with no idle cycle between them.

Top module: `apb_xfer_ctrl`

## Requirements
- R1: After reset the block is in ST_IDLE. psel, penable and rsp_valid are 0 and cmd_ready is 1.
- R2: A command taken (cmd_valid and cmd_ready high at a rising edge) is presented in the next cycle as ST_SETUP, with psel=1 and penable=0. ST_SETUP lasts exactly one cycle, whatever pready is, and is followed by ST_ACCESS. paddr, pwdata and pprot equal the command's values.
- R3: In ST_ACCESS (psel=1, penable=1) a transfer completes only on a rising edge where pready is 1. Otherwise the block stays in ST_ACCESS for any number of wait cycles.
- R4: paddr, pwrite, pwdata, pstrb and pprot do not change from the ST_SETUP cycle through the last ST_ACCESS cycle of a transfer.
- R5: pwrite is 1 for a write and 0 for a read. For a write, pstrb equals the command strobes, where bit i enables byte lane i (pwdata bits 8i+7..8i). For a read, pstrb is all zeros.
- R6: rsp_valid is high for exactly the one cycle after each completing edge. In that cycle rsp_err equals pslverr as sampled on the completing edge only. rsp_rdata equals prdata from that edge for a read, and 0 for a write.
- R7: cmd_ready is 1 in ST_IDLE and in ST_ACCESS while pready is 1. It is 0 in ST_SETUP and in a waiting ST_ACCESS.
- R8: When a transfer completes with cmd_valid high, the next cycle is ST_SETUP for the new command and psel stays high, with no idle cycle.
- R9: When a transfer completes with cmd_valid low, the block returns to ST_IDLE with psel and penable low.
- R10: penable is never high while psel is low.
- R11: rst_n low forces psel and penable low and the block to ST_IDLE at once, without waiting for a clock edge, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Requester offers a command |
| cmd_ready | output | 1 | Command is taken on this edge if valid |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Write data |
| cmd_strb | input | DATA_W/8 | Byte-lane enables for a write |
| cmd_prot | input | 3 | Protection attributes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| rsp_err | output | 1 | Completer error for the transfer |
| psel | output | 1 | Completer select |
| penable | output | 1 | Access phase enable |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pstrb | output | DATA_W/8 | Bus byte strobes |
| pprot | output | 3 | Bus protection |
| prdata | input | DATA_W | Completer read data |
| pready | input | 1 | Completer ready |
| pslverr | input | 1 | Completer error |

## Verification
Two functions meet on the completing edge of ST_ACCESS:

- the retirement of one transfer, which must produce its response;
- the acceptance of the next command, which must launch a fresh ST_SETUP.

The bench provokes this collision by issuing commands back to back, with zero and non-zero wait states. It judges the collision in three ways:

- a scoreboard pairs every response with the command that caused it;
- the completer model compares each transfer's fields with the expected command;
- a gap counter shows that psel never drops during the chained burst.

A completer that raises ready during ST_SETUP, and that drives junk error and data during wait cycles, also shows that neither early ready nor non-final error values leak into the result.

// File: rtl/apb_xfer_pkg.sv
package apb_xfer_pkg;

    localparam int PROT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/apb_xfer_fsm.sv
module apb_xfer_fsm
    import apb_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic pready,
    output logic cmd_ready,
    output logic accept,
    output logic complete,
    output logic psel,
    output logic penable
);

    xfer_state_e state_q;
    xfer_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: go, park, arm, stall, chain, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cmd_valid ? ST_SETUP : ST_IDLE;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: begin
                if (pready) begin
                    state_d = cmd_valid ? ST_SETUP : ST_IDLE;
                end else begin
                    state_d = ST_ACCESS;
                end
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        psel      = 1'b0;
        penable   = 1'b0;
        cmd_ready = 1'b0;
        complete  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
            end
            ST_SETUP: begin
                psel = 1'b1;
            end
            ST_ACCESS: begin
                psel      = 1'b1;
                penable   = 1'b1;
                complete  = pready;
                cmd_ready = pready;
            end
            default: begin
                cmd_ready = 1'b0;
            end
        endcase
        accept = cmd_valid & cmd_ready;
    end

endmodule

// File: rtl/apb_xfer_slot.sv
module apb_xfer_slot
    import apb_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [STRB_W-1:0] cmd_strb,
    input  logic [PROT_W-1:0] cmd_prot,
    output logic [ADDR_W-1:0] paddr,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    output logic [STRB_W-1:0] pstrb,
    output logic [PROT_W-1:0] pprot
);

    logic [STRB_W-1:0] lane_en;

    // Byte lanes are enabled only for writes
    for (genvar l = 0; l < STRB_W; l++) begin : g_lane
        assign lane_en[l] = cmd_write & cmd_strb[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr  <= '0;
            pwrite <= 1'b0;
            pwdata <= '0;
            pstrb  <= '0;
            pprot  <= '0;
        end else if (accept) begin
            paddr  <= cmd_addr;
            pwrite <= cmd_write;
            pwdata <= cmd_wdata;
            pstrb  <= lane_en;
            pprot  <= cmd_prot;
        end
    end

endmodule

// File: rtl/apb_xfer_rsp.sv
module apb_xfer_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic              xfer_write,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= complete;
            if (complete) begin
                rsp_rdata <= xfer_write ? '0 : prdata;
                rsp_err   <= pslverr;
            end
        end
    end

endmodule

// File: rtl/apb_xfer_ctrl.sv
module apb_xfer_ctrl
    import apb_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic                  cmd_write,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic [DATA_W/8-1:0]   cmd_strb,
    input  logic [PROT_W-1:0]     cmd_prot,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  rsp_err,
    output logic                  psel,
    output logic                  penable,
    output logic [ADDR_W-1:0]     paddr,
    output logic                  pwrite,
    output logic [DATA_W-1:0]     pwdata,
    output logic [DATA_W/8-1:0]   pstrb,
    output logic [PROT_W-1:0]     pprot,
    input  logic [DATA_W-1:0]     prdata,
    input  logic                  pready,
    input  logic                  pslverr
);

    localparam int STRB_W = DATA_W / 8;

    logic accept;
    logic complete;

    apb_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .pready    (pready),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .complete  (complete),
        .psel      (psel),
        .penable   (penable)
    );

    apb_xfer_slot #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STRB_W (STRB_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd_addr  (cmd_addr),
        .cmd_write (cmd_write),
        .cmd_wdata (cmd_wdata),
        .cmd_strb  (cmd_strb),
        .cmd_prot  (cmd_prot),
        .paddr     (paddr),
        .pwrite    (pwrite),
        .pwdata    (pwdata),
        .pstrb     (pstrb),
        .pprot     (pprot)
    );

    apb_xfer_rsp #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .complete   (complete),
        .xfer_write (pwrite),
        .prdata     (prdata),
        .pslverr    (pslverr),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err)
    );

endmodule

// File: rtl/apb_xfer_ctrl_chk.sv
module apb_xfer_ctrl_chk
    import apb_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic                psel,
    input logic                penable,
    input logic                pready,
    input logic                pslverr,
    input logic [ADDR_W-1:0]   paddr,
    input logic                pwrite,
    input logic [DATA_W-1:0]   pwdata,
    input logic [DATA_W/8-1:0] pstrb,
    input logic [PROT_W-1:0]   pprot,
    input logic [DATA_W-1:0]   prdata,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                rsp_err
);

    // R10
    en_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);

    // R2
    take_to_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> psel && !penable);

    // R2
    setup_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable);

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> psel && penable);

    // R4
    setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> $stable(paddr) && $stable(pwrite) && $stable(pwdata)
                             && $stable(pstrb) && $stable(pprot));

    // R4
    wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> $stable(paddr) && $stable(pwrite)
                                       && $stable(pwdata) && $stable(pstrb) && $stable(pprot));

    // R5
    read_strb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !pwrite |-> pstrb == '0);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready |=> rsp_valid);

    // R6
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pready) |=> !rsp_valid);

    // R6
    rsp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready |=> rsp_err == $past(pslverr));

    // R6
    rsp_rdata_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready && !pwrite |=> rsp_rdata == $past(prdata));

    // R6
    rsp_rdata_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready && pwrite |=> rsp_rdata == '0);

    // R7
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !psel || (penable && pready));

    // R8
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready && cmd_valid |=> psel && !penable);

    // R9
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready && !cmd_valid |=> !psel && !penable);

endmodule

bind apb_xfer_ctrl apb_xfer_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .psel      (psel),
    .penable   (penable),
    .pready    (pready),
    .pslverr   (pslverr),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .pstrb     (pstrb),
    .pprot     (pprot),
    .prdata    (prdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
);

// File: tb/apb_xfer_ctrl_bench.sv
module apb_xfer_ctrl_bench;

    // 50 MHz: period of 20 time units (ns)
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [3:0]  cmd_strb = '0;
    logic [2:0]  cmd_prot = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        psel;
    logic        penable;
    logic [31:0] paddr;
    logic        pwrite;
    logic [31:0] pwdata;
    logic [3:0]  pstrb;
    logic [2:0]  pprot;
    logic [31:0] prdata = '0;
    logic        pready = 1'b0;
    logic        pslverr = 1'b0;

    always #10 clk = ~clk;

    apb_xfer_ctrl u_apb_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .cmd_strb(cmd_strb), .cmd_prot(cmd_prot), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .psel(psel), .penable(penable),
        .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb),
        .pprot(pprot), .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        w;
        logic [31:0] d;
        logic [3:0]  s;
        logic [2:0]  p;
    } bus_item_t;

    typedef struct packed {
        logic [31:0] d;
        logic        e;
    } rsp_item_t;

    bus_item_t   bus_q[$];
    rsp_item_t   rsp_q[$];
    int          wait_q[$];
    logic [31:0] ref_mem [16];
    logic [31:0] cpl_mem [16];

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit early_rdy = 1'b0;
    bit burst = 1'b0;
    int gap_cnt = 0;
    int acc_cnt = 0;
    int setup_cnt = 0;
    bit cmpl_d = 1'b0;
    bus_item_t s_hold;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Completer model and response monitor, both at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            acc_cnt = 0;
            setup_cnt = 0;
            cmpl_d = 1'b0;
            pready = 1'b0;
            pslverr = 1'b0;
        end else begin
            // Scoreboard (R6): pulse right after each completing edge
            if (rsp_valid || cmpl_d)
                chk(rsp_valid == cmpl_d, "R6", "rsp_valid pulse", {31'b0, rsp_valid}, {31'b0, cmpl_d});
            if (rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected response", rsp_rdata, 32'h0);
                end else begin
                    rsp_item_t e;
                    e = rsp_q.pop_front();
                    chk(rsp_rdata == e.d, "R6", "rsp_rdata", rsp_rdata, e.d);
                    chk(rsp_err == e.e, "R6", "rsp_err", {31'b0, rsp_err}, {31'b0, e.e});
                end
            end
            cmpl_d = 1'b0;
            if (burst && !psel) gap_cnt++;
            chk(!(penable && !psel), "R10", "enable without select", {31'b0, penable}, 32'h0);

            pready = 1'b0;
            pslverr = 1'b0;
            prdata = 32'h0;
            if (psel && !penable) begin
                setup_cnt++;
                s_hold = '{a: paddr, w: pwrite, d: pwdata, s: pstrb, p: pprot};
                if (early_rdy) pready = 1'b1;
            end else if (psel && penable) begin
                int w;
                w = (wait_q.size() != 0) ? wait_q[0] : 0;
                chk({paddr, pwrite, pwdata, pstrb, pprot} == s_hold, "R4", "fields held",
                    paddr, s_hold.a);
                if (acc_cnt >= w) begin
                    bus_item_t x;
                    pready = 1'b1;
                    pslverr = paddr[31];
                    prdata = cpl_mem[paddr[5:2]];
                    chk(setup_cnt == 1, "R2", "setup cycles", setup_cnt, 32'd1);
                    if (bus_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected transfer", paddr, 32'h0);
                    end else begin
                        x = bus_q.pop_front();
                        chk(paddr == x.a, "R2", "paddr", paddr, x.a);
                        chk(pwdata == x.d, "R2", "pwdata", pwdata, x.d);
                        chk(pprot == x.p, "R2", "pprot", {29'b0, pprot}, {29'b0, x.p});
                        chk(pwrite == x.w, "R5", "pwrite", {31'b0, pwrite}, {31'b0, x.w});
                        chk(pstrb == x.s, "R5", "pstrb", {28'b0, pstrb}, {28'b0, x.s});
                    end
                    if (pwrite) begin
                        for (int l = 0; l < 4; l++)
                            if (pstrb[l]) cpl_mem[paddr[5:2]][8*l +: 8] = pwdata[8*l +: 8];
                    end
                    if (wait_q.size() != 0) void'(wait_q.pop_front());
                    acc_cnt = 0;
                    setup_cnt = 0;
                    cmpl_d = 1'b1;
                end else begin
                    // junk while waiting: must not reach the response (R6)
                    pslverr = 1'b1;
                    prdata = 32'hDEAD_BEEF;
                    acc_cnt++;
                end
            end
        end
    end

    // R7: ready window sampled mid-cycle
    always @(negedge clk) begin
        #5;
        if (rst_n)
            chk(cmd_ready == (!psel || (penable && pready)), "R7", "cmd_ready",
                {31'b0, cmd_ready}, {31'b0, (!psel || (penable && pready))});
    end

    // Driver: called at negedge+1, returns at negedge+1 after acceptance
    task automatic send(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input logic [3:0] s, input logic [2:0] p, input int waits);
        rsp_item_t r;
        bit ok;
        bus_q.push_back('{a: a, w: w, d: d, s: (w ? s : 4'b0), p: p});
        wait_q.push_back(waits);
        r.e = a[31];
        if (w) begin
            r.d = 32'h0;
            for (int l = 0; l < 4; l++)
                if (s[l]) ref_mem[a[5:2]][8*l +: 8] = d[8*l +: 8];
        end else begin
            r.d = ref_mem[a[5:2]];
        end
        rsp_q.push_back(r);
        cmd_valid = 1'b1;
        cmd_addr = a;
        cmd_write = w;
        cmd_wdata = d;
        cmd_strb = s;
        cmd_prot = p;
        ok = 1'b0;
        while (!ok) begin
            #5;
            ok = cmd_ready;
            @(negedge clk);
            #1;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (rsp_q.size() != 0 && t < 500) begin
            @(negedge clk);
            #1;
            t++;
        end
        @(negedge clk);
        #1;
    endtask

    initial begin
        #400000;
        chk(1'b0, "R3", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            ref_mem[i] = 32'h1000_0000 + i * 32'h0101;
            cpl_mem[i] = 32'h1000_0000 + i * 32'h0101;
        end
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(psel == 1'b0 && penable == 1'b0, "R1", "bus idle in reset", {30'b0, psel, penable}, 32'h0);
        chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1", "handshake in reset",
            {30'b0, cmd_ready, rsp_valid}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(psel == 1'b0 && cmd_ready == 1'b1, "R1", "idle after release", {30'b0, psel, cmd_ready}, 32'h1);

        // R2 R5 R6: zero-wait full write, then reads with waits (R3)
        send(32'h0000_0004, 1'b1, 32'hA1B2_C3D4, 4'hF, 3'd2, 0);
        drain();
        send(32'h0000_0004, 1'b0, 32'hFFFF_FFFF, 4'hF, 3'd1, 2);
        drain();
        // R5: partial strobes, lanes 0 and 2
        send(32'h0000_0008, 1'b1, 32'h1122_3344, 4'b0101, 3'd0, 1);
        send(32'h0000_0008, 1'b0, 32'h0, 4'hF, 3'd0, 0);
        drain();
        // R6: error address space (bit 31 set)
        send(32'h8000_0010, 1'b1, 32'h5555_AAAA, 4'b1000, 3'd4, 0);
        send(32'h8000_0014, 1'b0, 32'h0, 4'h0, 3'd7, 3);
        drain();
        // R3 R4: long wait
        send(32'h0000_003C, 1'b1, 32'hCAFE_F00D, 4'b0110, 3'd5, 7);
        send(32'h0000_003C, 1'b0, 32'h0, 4'hF, 3'd3, 7);
        drain();
        // R2: completer raises ready already in SETUP
        early_rdy = 1'b1;
        send(32'h0000_0020, 1'b1, 32'h0BAD_F00D, 4'hF, 3'd1, 0);
        send(32'h0000_0020, 1'b0, 32'h0, 4'hF, 3'd1, 2);
        drain();
        early_rdy = 1'b0;

        // R8: chained burst, mixed directions and waits, psel must not drop
        gap_cnt = 0;
        send(32'h0000_0030, 1'b1, 32'h0102_0304, 4'hF, 3'd0, 0);
        burst = 1'b1;
        send(32'h0000_0030, 1'b0, 32'h0, 4'hF, 3'd0, 0);
        send(32'h0000_0034, 1'b1, 32'hF0E0_D0C0, 4'b1100, 3'd6, 2);
        send(32'h0000_0034, 1'b0, 32'h0, 4'hF, 3'd2, 0);
        send(32'h8000_0000, 1'b0, 32'h0, 4'hF, 3'd2, 1);
        burst = 1'b0;
        drain();
        chk(gap_cnt == 0, "R8", "idle cycles inside burst", gap_cnt, 32'd0);

        // R9: single transfer then nothing
        send(32'h0000_000C, 1'b0, 32'h0, 4'hF, 3'd0, 1);
        drain();
        chk(psel == 1'b0 && penable == 1'b0, "R9", "return to idle", {30'b0, psel, penable}, 32'h0);
        chk(cmd_ready == 1'b1, "R9", "ready in idle", {31'b0, cmd_ready}, 32'h1);

        // R11: asynchronous reset in the middle of a long access
        send(32'h0000_0018, 1'b0, 32'h0, 4'hF, 3'd0, 20);
        repeat (3) @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        chk(psel == 1'b0 && penable == 1'b0, "R11", "bus dropped at once", {30'b0, psel, penable}, 32'h0);
        chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R11", "handshake at reset",
            {30'b0, cmd_ready, rsp_valid}, 32'h2);
        bus_q.delete();
        rsp_q.delete();
        wait_q.delete();
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        send(32'h0000_0008, 1'b0, 32'h0, 4'hF, 3'd0, 1);
        drain();
        chk(rsp_q.size() == 0 && bus_q.size() == 0, "R11", "traffic after reset",
            rsp_q.size() + bus_q.size(), 32'd0);
        finish_run();
    end

endmodule